// File: doc/BRIEF.md
# Register Window with Decaying Bus Latch

This block is the CPU-facing register window of a video display processor. The CPU sees eight byte-wide register slots, and they repeat across the whole address window because only the three lowest address bits are decoded. Every byte the CPU writes to any slot is also captured in an internal 8-bit bus latch. A read of a slot that has no real read data returns that latch. A read of the status slot returns three live status bits, with the lower five bits taken from the latch.

The latch does not hold its value forever. An idle counter restarts each time the latch is loaded. If the latch goes `DECAY_CYCLES` clock edges without a load, it clears to zero. A read of a readable slot also loads the returned byte into the latch. Read data is registered and appears one clock after the read strobe. The rest of the processor supplies the status bits and the data for the two fully readable slots.

Top module: `vdp_regport`

## Requirements
- R1: Only `cpu_addr[2:0]` selects the slot. Any two addresses with equal low three bits behave identically.
- R2: On a clock edge with `cs` and `wr` high, the latch loads `wdata`, whatever the slot.
- R3: Slots 2, 4 and 7 are readable. A read of slot 4 returns `spr_data` and a read of slot 7 returns `vram_data`.
- R4: A read of slot 0, 1, 3, 5 or 6 returns the current latch value.
- R5: A read of slot 2 returns `status_in` in bits 7:5 and latch bits 4:0 in bits 4:0.
- R6: If the latch is not loaded on `DECAY_CYCLES` consecutive clock edges, it clears to zero on the last of them. Until then it keeps its value. A read of a write-only slot is not a load.
- R7: A read of slot 2, 4 or 7 loads the returned byte into the latch and restarts the decay count.
- R8: `rdata` updates only on an edge where `cs` and `rd` are high, and holds otherwise. With `cs` low, strobes have no effect.
- R9: Reset clears the latch, the decay count and `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU address within the window |
| cs | input | 1 | Chip select for the window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| status_in | input | 3 | Live status bits for slot 2, bits 7:5 |
| spr_data | input | 8 | Read data for slot 4 |
| vram_data | input | 8 | Read data for slot 7 |
| rdata | output | 8 | Registered read data |

## Verification
The hardest situation to reach is the exact edge where decay takes effect. A read one edge early must still return the latched byte, and a read one edge later must return zero. The bench uses a small `DECAY_CYCLES` and counts idle edges from the load edge. It then probes through a write-only slot, because such a read does not restart the count. The same counting checks that a second write, and a read of a readable slot, each restart the window.

// File: rtl/vdp_regport.sv
module vdp_regport #(
  parameter int ADDR_W       = 13,
  parameter int DECAY_CYCLES = 5_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic [2:0]        status_in,
  input  logic [7:0]        spr_data,
  input  logic [7:0]        vram_data,
  output logic [7:0]        rdata
);
  localparam int CNT_W = $clog2(DECAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DECAY_CYCLES - 1);

  logic [2:0]       slot;
  logic [7:0]       bus_q;
  logic [CNT_W-1:0] idle_q;
  logic             readable, rd_go, wr_go, load, at_limit;
  logic [7:0]       rd_val;

  assign slot     = cpu_addr[2:0];
  assign readable = (slot == 3'd2) || (slot == 3'd4) || (slot == 3'd7);
  assign rd_go    = cs && rd;
  assign wr_go    = cs && wr;
  assign load     = wr_go || (rd_go && readable);
  assign at_limit = (idle_q == LIMIT);

  always_comb begin
    case (slot)
      3'd2:    rd_val = {status_in, bus_q[4:0]};
      3'd4:    rd_val = spr_data;
      3'd7:    rd_val = vram_data;
      default: rd_val = bus_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q  <= '0;
      idle_q <= '0;
      rdata  <= '0;
    end else begin
      if (rd_go) rdata <= rd_val;
      if (load) begin
        bus_q  <= wr_go ? wdata : rd_val;
        idle_q <= '0;
      end else if (at_limit) begin
        bus_q  <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> bus_q == $past(wdata)); // R2
  AST_WO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !readable) |=> rdata == $past(bus_q)); // R4
  AST_STATUS_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && slot == 3'd2) |=> rdata == {$past(status_in), $past(bus_q[4:0])}); // R5
  AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !wr_go && readable) |=> bus_q == rdata); // R7
  AST_DECAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !load) |=> bus_q == 8'h00); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !at_limit) |=> $stable(bus_q)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata)); // R8
endmodule

// File: tb/test_vdp_regport.sv
`timescale 1ns/1ps
module test_vdp_regport;
  localparam int DK = 40;
  localparam int NV = 14;
  localparam logic [3:0] OW = 4'd1, OR = 4'd2;
  // {op[39:36], addr[35:20], wdata[15:8], expected[7:0]}
  localparam logic [39:0] VEC [NV] = '{
    {OW, 16'h2007, 4'h0, 8'h1F, 8'h00},
    {OR, 16'h2000, 4'h0, 8'h00, 8'h1F},
    {OR, 16'h2002, 4'h0, 8'h00, 8'hBF},
    {OR, 16'h2001, 4'h0, 8'h00, 8'hBF},
    {OW, 16'h200B, 4'h0, 8'h46, 8'h00},
    {OR, 16'h1FFD, 4'h0, 8'h00, 8'h46},
    {OR, 16'h2004, 4'h0, 8'h00, 8'hA5},
    {OR, 16'h2006, 4'h0, 8'h00, 8'hA5},
    {OR, 16'h200F, 4'h0, 8'h00, 8'h3C},
    {OR, 16'h0008, 4'h0, 8'h00, 8'h3C},
    {OW, 16'h1230, 4'h0, 8'h00, 8'h00},
    {OR, 16'h3FFA, 4'h0, 8'h00, 8'hA0},
    {OR, 16'h2003, 4'h0, 8'h00, 8'hA0},
    {OR, 16'h0005, 4'h0, 8'h00, 8'hA0}
  };

  logic clk = 0, rst_n = 0, cs = 0, rd = 0, wr = 0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0, spr = 8'hA5, vram = 8'h3C, rdata;
  logic [2:0] stat = 3'b101;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vdp_regport #(.ADDR_W(13), .DECAY_CYCLES(DK)) i_vdp_regport (
    .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cs(cs), .rd(rd), .wr(wr),
    .wdata(wdata), .status_in(stat), .spr_data(spr), .vram_data(vram),
    .rdata(rdata));

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%02h expected=%02h", req, rdata, exp);
    end
  endtask

  task automatic bus(input logic c, input logic r, input logic w,
                     input logic [12:0] a, input logic [7:0] d);
    cs = c; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R9 reset rdata", 8'h00);
    bus(1, 1, 0, 13'h0000, 0);
    check("R9 reset latch", 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39:36] == OW) bus(1, 0, 1, VEC[i][32:20], VEC[i][15:8]);
      else begin
        bus(1, 1, 0, VEC[i][32:20], 8'h00);
        check($sformatf("R1/R3/R4/R5/R7 vec %0d", i), VEC[i][7:0]);
      end
    end

    // R8: chip select gating and rdata hold
    bus(1, 0, 1, 13'h0001, 8'h55);
    bus(0, 0, 1, 13'h0001, 8'hAA);
    bus(0, 1, 0, 13'h0002, 8'h00);
    check("R8 rd ignored with cs low", 8'hA0);
    bus(1, 1, 0, 13'h0000, 8'h00);
    check("R8 wr ignored with cs low", 8'h55);
    idle(3);
    check("R8 rdata holds", 8'h55);

    // R6: decay edge
    bus(1, 0, 1, 13'h0006, 8'h77);
    idle(DK - 1);
    bus(1, 1, 0, 13'h0000, 8'h00);
    check("R6 last edge before decay", 8'h77);
    bus(1, 0, 1, 13'h0006, 8'h77);
    idle(DK);
    bus(1, 1, 0, 13'h0000, 8'h00);
    check("R6 decayed to zero", 8'h00);

    // R6/R2: second write restarts window
    bus(1, 0, 1, 13'h0003, 8'h12);
    idle(DK - 5);
    bus(1, 0, 1, 13'h0005, 8'h34);
    idle(DK - 1);
    bus(1, 1, 0, 13'h0001, 8'h00);
    check("R2 write restarts decay", 8'h34);

    // R7: readable read restarts window
    bus(1, 0, 1, 13'h0003, 8'h12);
    idle(DK - 5);
    bus(1, 1, 0, 13'h0007, 8'h00);
    idle(DK - 1);
    bus(1, 1, 0, 13'h0001, 8'h00);
    check("R7 readable read restarts decay", 8'h3C);

    // R9: reset mid-operation
    bus(1, 0, 1, 13'h0000, 8'hEE);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    check("R9 rdata cleared", 8'h00);
    bus(1, 1, 0, 13'h0003, 8'h00);
    check("R9 latch cleared", 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: rdata=%02h expected=done", rdata);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule